// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns single transfer requests from a processor core into external bus cycles on a 16-bit address, 8-bit data bus. The low address byte and the data byte share one set of pins. Five transfer kinds are supported: opcode fetch, memory read, memory write, port read and port write. Each machine cycle runs three phases. In phase A the address is on the pins and the latch strobe is high. In phase B the read or write strobe falls. Phase C can be repeated as wait clocks while the target holds its ready input low. A two-bit status code and a memory/port select pin tell the outside world what kind of cycle is running.

Requests arrive on a valid/ready interface. `req_ready` is high only while the sequencer is idle, no bus hold is requested and the core is not halted. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold its fields stable until then. Read data comes back as a one-clock `rsp_valid` pulse, which cannot be stalled, in the clock after the cycle ends.

Another bus master can take the bus through `hold_req`/`hold_ack`. A halted core also releases the bus. Tri-state drivers are modelled as separate output-enable pins: `addr_hi_oe`, `ad_oe` and `ctl_oe`. The address latch strobe has no enable and is always driven.

Top module: `mbs_top`

## Requirements
- R1: In phase A (the first clock after a request is taken) `ale` is 1, `ad_oe` is 1, `ad_out` carries address bits 7:0 and `addr_hi_oe` is 1. `ale` is 0 in every other clock.
- R2: From phase A until the next request is taken, `stat` shows the cycle kind and `io_m` stays constant. The `stat` codes are 2'b11 for fetch, 2'b10 for memory or port read, and 2'b01 for memory or port write. `io_m` is 1 for port cycles and 0 for memory cycles.
- R3: For memory cycles `addr_hi` carries address bits 15:8. For port cycles `addr_hi` carries the 8-bit port number (address bits 7:0), which is the same value as on `ad_out` in phase A.
- R4: In phase B and every phase-C clock, a fetch or read holds `rd_n` at 0 with `ad_oe` at 0. A write holds `wr_n` at 0 with `ad_oe` at 1 and `ad_out` equal to the write data, stable up to the clock edge that ends the strobe. `rd_n` and `wr_n` are never both 0.
- R5: `bus_ready` is sampled at the end of each phase-C clock. While it is 0 another phase-C clock follows and the strobe stays at 0. The cycle lasts 3 + W clocks for W low samples.
- R6: For a fetch or read, `ad_in` is captured at the edge that ends the last phase-C clock. `rsp_valid` is 1 for exactly the next clock, with `rsp_data` equal to the captured value. A write produces no `rsp_valid`.
- R7: `req_ready` is 1 only while idle with `hold_req` and `core_halt` both 0. If `hold_req` and `req_valid` are both 1 in the same idle clock, no cycle starts.
- R8: A `hold_req` raised during a cycle does not shorten it. After the cycle completes, `hold_ack` rises in the following clock. While `hold_ack` is 1, `addr_hi_oe`, `ad_oe` and `ctl_oe` are 0.
- R9: After `hold_req` falls, `hold_ack` is 0 for one clock with all enables still 0. The clock after that drives the address and control pins again and `req_ready` returns to 1.
- R10: While `core_halt` is 1 in idle, the next clock has `stat` = 2'b00 and all three output enables at 0, with `ale` at 0.
- R11: After reset `rd_n` and `wr_n` are 1, `ale`, `hold_ack` and `rsp_valid` are 0, `stat` is 2'b00, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_kind | input | 3 | 0 fetch, 1 mem read, 2 mem write, 3 port read, 4 port write |
| req_addr | input | 16 | Address (port number in bits 7:0) |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 8 | Read data |
| core_halt | input | 1 | Core halted; release bus when idle |
| bus_ready | input | 1 | Target ready, sampled in phase C |
| hold_req | input | 1 | External master requests the bus |
| hold_ack | output | 1 | Bus released to external master |
| addr_hi | output | 8 | High address byte |
| addr_hi_oe | output | 1 | Drive enable for addr_hi |
| ad_out | output | 8 | Shared low address / write data out |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 8 | Shared pins read back |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 port cycle, 0 memory cycle |
| ctl_oe | output | 1 | Drive enable for rd_n, wr_n, io_m |
| stat | output | 2 | Cycle status code |

## Verification
A bus-hold request can land in the same clock as other work. It may coincide with a fresh core request in idle, or arrive while a cycle is stretched by wait clocks. The bench raises `hold_req` during phase B of a read that has a wait clock, and checks that the strobe and wait clocks run to the end, the read data returns, and `hold_ack` appears only a clock later. It also raises `hold_req` together with `req_valid` in idle, and checks that `req_ready` is low, no `ale` pulse appears, and the request runs correctly after the bus is returned.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PA, S_PB, S_PC, S_HOLD, S_REL, S_HALT
  } st_e;

  function automatic logic kind_is_wr(kind_e k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic kind_is_io(kind_e k);
    return (k == K_IORD) || (k == K_IOWR);
  endfunction

  function automatic logic [1:0] kind_stat(kind_e k);
    logic [1:0] s;
    case (k)
      K_FETCH:        s = 2'b11;
      K_MWR, K_IOWR:  s = 2'b01;
      default:        s = 2'b10;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
  import mbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic core_halt,
  input  logic hold_req,
  input  logic bus_ready,
  output st_e  st,
  output logic req_ready,
  output logic accept,
  output logic done,
  output logic hold_ack
);
  st_e st_nx;

  assign req_ready = (st == S_IDLE) && !hold_req && !core_halt;
  assign accept    = req_ready && req_valid;
  assign done      = (st == S_PC) && bus_ready;
  assign hold_ack  = (st == S_HOLD);

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: begin
        if (hold_req)       st_nx = S_HOLD;
        else if (core_halt) st_nx = S_HALT;
        else if (req_valid) st_nx = S_PA;
      end
      S_PA:   st_nx = S_PB;
      S_PB:   st_nx = S_PC;
      S_PC:   if (bus_ready) st_nx = S_IDLE;
      S_HOLD: if (!hold_req) st_nx = S_REL;
      S_REL:  st_nx = S_IDLE;
      S_HALT: begin
        if (hold_req)        st_nx = S_HOLD;
        else if (!core_halt) st_nx = S_IDLE;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end

  a_r8_no_cut_short: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PB) |=> (st == S_PC));
  a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PC && !bus_ready) |=> (st == S_PC));
  a_r7_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (st == S_IDLE && !hold_req));
  a_r9_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && !hold_req) |=> (st == S_REL));
endmodule

// File: rtl/mbs_cap.sv
module mbs_cap
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              done,
  input  kind_e             req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output kind_e             lat_kind,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_wdata,
  output logic [1:0]        stat_q,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_kind  <= K_FETCH;
      lat_addr  <= '0;
      lat_wdata <= '0;
      stat_q    <= 2'b00;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= done && !kind_is_wr(lat_kind);
      if (done && !kind_is_wr(lat_kind)) rsp_data <= ad_in;
      if (accept) begin
        lat_kind  <= req_kind;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
        stat_q    <= kind_stat(req_kind);
      end
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r2_kind_held: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(lat_kind) && $stable(stat_q));
endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  st_e               st,
  input  kind_e             lat_kind,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [DATA_W-1:0] lat_wdata,
  input  logic [1:0]        stat_q,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic              addr_hi_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              ctl_oe,
  output logic [1:0]        stat
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic is_wr, is_io;
  assign is_wr = kind_is_wr(lat_kind);
  assign is_io = kind_is_io(lat_kind);

  always_comb begin
    addr_hi    = is_io ? HI_W'(lat_addr[DATA_W-1:0]) : lat_addr[ADDR_W-1:DATA_W];
    addr_hi_oe = 1'b1;
    ctl_oe     = 1'b1;
    ad_out     = lat_addr[DATA_W-1:0];
    ad_oe      = 1'b0;
    ale        = 1'b0;
    rd_n       = 1'b1;
    wr_n       = 1'b1;
    io_m       = is_io;
    stat       = stat_q;
    case (st)
      S_PA: begin
        ale   = 1'b1;
        ad_oe = 1'b1;
      end
      S_PB, S_PC: begin
        rd_n  = is_wr;
        wr_n  = !is_wr;
        ad_oe = is_wr;
        if (is_wr) ad_out = lat_wdata;
      end
      S_HOLD, S_REL, S_HALT: begin
        addr_hi_oe = 1'b0;
        ctl_oe     = 1'b0;
        if (st == S_HALT) stat = 2'b00;
      end
      default: ;
    endcase
  end

  a_r1_ale_with_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && addr_hi_oe && rd_n && wr_n));
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  a_r4_read_floats: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  a_r4_wdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> ($stable(ad_out) && ad_oe));
  a_r8_hold_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) |-> (!ad_oe && !addr_hi_oe && !ctl_oe && !ale));
  a_r2_iom_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PB || st == S_PC) |-> $stable(io_m));
endmodule

// File: rtl/mbs_top.sv
module mbs_top
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              core_halt,
  input  logic              bus_ready,
  input  logic              hold_req,
  output logic              hold_ack,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic              addr_hi_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              ctl_oe,
  output logic [1:0]        stat
);
  st_e               st;
  logic              accept, done;
  kind_e             lat_kind;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic [1:0]        stat_q;

  mbs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .core_halt(core_halt),
    .hold_req(hold_req), .bus_ready(bus_ready), .st(st), .req_ready(req_ready),
    .accept(accept), .done(done), .hold_ack(hold_ack)
  );

  mbs_cap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .accept(accept), .done(done),
    .req_kind(kind_e'(req_kind)), .req_addr(req_addr), .req_wdata(req_wdata),
    .ad_in(ad_in), .lat_kind(lat_kind), .lat_addr(lat_addr),
    .lat_wdata(lat_wdata), .stat_q(stat_q), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  mbs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .st(st), .lat_kind(lat_kind),
    .lat_addr(lat_addr), .lat_wdata(lat_wdata), .stat_q(stat_q),
    .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe), .ad_out(ad_out), .ad_oe(ad_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .ctl_oe(ctl_oe),
    .stat(stat)
  );

  a_r6_no_write_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_n) |=> !rsp_valid);
endmodule

// File: tb/mbs_top_tb_top.sv
`timescale 1ns/1ps
module mbs_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, core_halt = 1'b0, bus_ready = 1'b1, hold_req = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, ad_in = '0;
  logic req_ready, rsp_valid, hold_ack, addr_hi_oe, ad_oe, ale, rd_n, wr_n, io_m, ctl_oe;
  logic [7:0] rsp_data, addr_hi, ad_out;
  logic [1:0] stat;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mbs_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .core_halt(core_halt),
    .bus_ready(bus_ready), .hold_req(hold_req), .hold_ack(hold_ack),
    .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
    .ctl_oe(ctl_oe), .stat(stat)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // kind(3) addr(16) wdata(8) waits(4) rdata(8)
  localparam int NV = 8;
  localparam logic [38:0] VEC [NV] = '{
    {3'd0, 16'h1234, 8'h00, 4'd0, 8'hA5},
    {3'd1, 16'hBEEF, 8'h00, 4'd2, 8'h3C},
    {3'd2, 16'h8001, 8'h5A, 4'd0, 8'h00},
    {3'd3, 16'h0077, 8'h00, 4'd1, 8'hC3},
    {3'd4, 16'hFF42, 8'h99, 4'd3, 8'h00},
    {3'd2, 16'h00FF, 8'h01, 4'd1, 8'h00},
    {3'd1, 16'h7F80, 8'h00, 4'd0, 8'hFF},
    {3'd0, 16'hFFFF, 8'h00, 4'd4, 8'h5E}
  };

  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                           input logic [7:0] wd, input int waits,
                           input logic [7:0] rd, input logic hold_mid);
    logic wr, io;
    logic [1:0] es;
    wr = (k == 3'd2) || (k == 3'd4);
    io = (k == 3'd3) || (k == 3'd4);
    es = (k == 3'd0) ? 2'b11 : (wr ? 2'b01 : 2'b10);
    @(negedge clk);
    chk("R7 ready in idle", req_ready, 1);
    req_valid = 1; req_kind = k; req_addr = a; req_wdata = wd;
    @(negedge clk);  // phase A
    req_valid = 0; req_addr = 16'h0; req_wdata = 8'h0;
    chk("R1 ale", ale, 1);
    chk("R1 ad_oe", ad_oe, 1);
    chk("R1 low addr", ad_out, a[7:0]);
    chk("R3 high addr", addr_hi, io ? a[7:0] : a[15:8]);
    chk("R2 stat", stat, es);
    chk("R2 io_m", io_m, io);
    bus_ready = 0; ad_in = rd;
    @(negedge clk);  // phase B
    if (hold_mid) hold_req = 1;
    chk("R1 ale low", ale, 0);
    chk("R4 strobe", {rd_n, wr_n}, wr ? 2'b10 : 2'b01);
    chk("R4 ad_oe", ad_oe, wr);
    if (wr) chk("R4 wdata", ad_out, wd);
    for (int j = 0; j <= waits; j++) begin
      @(negedge clk);  // phase C
      bus_ready = (j >= waits);
      chk("R5 strobe held", {rd_n, wr_n}, wr ? 2'b10 : 2'b01);
      if (wr) chk("R4 wdata held", ad_out, wd);
      chk("R2 io_m held", io_m, io);
      chk("R8 no ack midcycle", hold_ack, 0);
    end
    @(negedge clk);  // idle after completion
    chk("R4 strobes released", {rd_n, wr_n}, 2'b11);
    chk("R6 rsp_valid", rsp_valid, !wr);
    if (!wr) chk("R6 rsp_data", rsp_data, rd);
    chk("R2 stat kept", stat, es);
    bus_ready = 1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 rd_n", rd_n, 1);
    chk("R11 wr_n", wr_n, 1);
    chk("R11 ale", ale, 0);
    chk("R11 hold_ack", hold_ack, 0);
    chk("R11 rsp_valid", rsp_valid, 0);
    chk("R11 stat", stat, 2'b00);
    chk("R11 req_ready", req_ready, 1);

    for (int i = 0; i < NV; i++)
      run_cycle(VEC[i][38:36], VEC[i][35:20], VEC[i][19:12],
                int'(VEC[i][11:8]), VEC[i][7:0], 1'b0);

    // R8: hold raised in phase B of a read with one wait clock
    run_cycle(3'd1, 16'h4321, 8'h00, 1, 8'h6B, 1'b1);
    chk("R7 ready low under hold", req_ready, 0);
    @(negedge clk);
    chk("R8 hold_ack", hold_ack, 1);
    chk("R8 addr float", addr_hi_oe, 0);
    chk("R8 ad float", ad_oe, 0);
    chk("R8 ctl float", ctl_oe, 0);
    chk("R6 single pulse", rsp_valid, 0);
    hold_req = 0;
    @(negedge clk);
    chk("R9 ack drops", hold_ack, 0);
    chk("R9 still floating", {addr_hi_oe, ctl_oe}, 2'b00);
    @(negedge clk);
    chk("R9 bus retaken", {addr_hi_oe, ctl_oe}, 2'b11);
    chk("R9 ready back", req_ready, 1);

    // R7: hold and request in the same idle clock
    hold_req = 1; req_valid = 1; req_kind = 3'd2; req_addr = 16'hA55A; req_wdata = 8'h77;
    #0.1;
    chk("R7 ready low with hold", req_ready, 0);
    @(negedge clk);
    chk("R7 no cycle started", ale, 0);
    chk("R7 hold won", hold_ack, 1);
    hold_req = 0; req_valid = 0;
    @(negedge clk);
    @(negedge clk);
    run_cycle(3'd2, 16'hA55A, 8'h77, 0, 8'h00, 1'b0);

    // R10: halt
    core_halt = 1;
    #0.1;
    chk("R7 ready low in halt", req_ready, 0);
    @(negedge clk);
    chk("R10 stat", stat, 2'b00);
    chk("R10 floats", {addr_hi_oe, ad_oe, ctl_oe}, 3'b000);
    chk("R10 ale", ale, 0);
    core_halt = 0;
    @(negedge clk);
    chk("R10 resume", req_ready, 1);
    run_cycle(3'd3, 16'h0010, 8'h00, 0, 8'h81, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule